// File: doc/BRIEF.md
# Legacy PC Physical Address Router

This block takes a 32-bit physical byte address from a CPU-side request port and decides which of four targets serves it: main RAM, the ROM array that holds the system BIOS and expansion ROMs, the video memory port, or no target. If no target serves the access, the write is dropped or an error is reported. The decode follows the classic layout of the first megabyte. The 128 KiB video window can be overlaid by system-management RAM. The 256 KiB at the top of the first megabyte is either ROM or shadow RAM, chosen by an external per-segment memory-type lookup. A top-of-4GB alias reaches the BIOS ROM.

The block also holds a small SMRAM control state with three bits: present, open and locked. A set pulse loads the state and a clear pulse wipes it. The state decides whether code fetches and data accesses to the video window reach RAM. The page of the local interrupt controller is never routed to memory.

Decoding is combinational. The route is captured one cycle after a valid request, and a response valid is raised in that cycle.

Top module: `pc_addr_router`

## Requirements
- R1: Every cycle with `req_valid_i` high is followed, in the next cycle, by `rsp_valid_o` high carrying that request's route. A cycle without a request gives `rsp_valid_o` low in the next cycle. Target codes: RAM=0, ROM=1, VIDEO=2, NONE=3. NONE responses carry index 0.
- R2: Data accesses to 0xA0000–0xBFFFF go to RAM (index = address) when SMRAM is open. Otherwise they go to VIDEO with index = address & 0x1FFFF.
- R3: A code fetch (read with `req_code_i` high) in 0xA0000–0xBFFFF goes to RAM when SMRAM is present and either open or `smm_mode_i` is high. Otherwise it goes to VIDEO.
- R4: A set pulse makes SMRAM present and loads open and locked from the inputs. A clear pulse wins over set and zeroes all three bits. `smram_data_ok_o` = present && (open || !locked).
- R5: With `pci_en_i` high, reads in 0xC0000–0xFFFFF take mem type 0 to ROM and type 1 to RAM. `shadow_seg_o` equals address bits [17:14].
- R6: With `pci_en_i` high, writes in 0xC0000–0xFFFFF are dropped (NONE, no error) for type 0 and go to RAM for type 1.
- R7: With `pci_en_i` high and a mem type of 2 or 3 in 0xC0000–0xFFFFF, the target is NONE and `rsp_type_err_o` is set.
- R8: ROM index: 0xE0000–0xFFFFF uses address & (BIOS size−1). 0xC0000–0xDFFFF uses (address & (expansion size−1)) + BIOS size.
- R9: At or above ~(BIOS size−1), reads go to ROM with index address & (BIOS size−1), and writes are dropped.
- R10: With `pci_en_i` low, reads below installed RAM inside 0xC0000–0xFFFFF go to ROM, and writes there are dropped.
- R11: A read that falls in no region gives NONE, `rsp_rdata_o` = 0xFF and `rsp_range_err_o`. Such a write gives NONE with no error flag.
- R12: An address whose bits [31:12] equal `apic_page_i` gives NONE with `rsp_apic_o`, ahead of every other rule.
- R13: Other addresses below `ram_mb_i` MiB go to RAM with index = address. Flags and read data are zero on every response except those listed above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_addr_i | input | 32 | Physical byte address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_code_i | input | 1 | Read is an instruction fetch |
| smm_mode_i | input | 1 | CPU is in system-management mode |
| smram_set_i | input | 1 | Load SMRAM state (present=1) |
| smram_open_i | input | 1 | Open value loaded by set |
| smram_lock_i | input | 1 | Locked value loaded by set |
| smram_clr_i | input | 1 | Clear all SMRAM state bits |
| pci_en_i | input | 1 | Shadow memory-type lookup in use |
| mem_type_i | input | 2 | Memory type of the addressed segment |
| ram_mb_i | input | 12 | Installed RAM in MiB |
| apic_page_i | input | 20 | Local interrupt controller page number |
| shadow_seg_o | output | 4 | 16 KiB segment index for the type lookup |
| smram_data_ok_o | output | 1 | SMRAM usable for data accesses |
| rsp_valid_o | output | 1 | Response present |
| rsp_target_o | output | 2 | Target code |
| rsp_index_o | output | 32 | Translated array index |
| rsp_rdata_o | output | 8 | Read data supplied by the router |
| rsp_range_err_o | output | 1 | Out-of-range read |
| rsp_type_err_o | output | 1 | Illegal memory type |
| rsp_apic_o | output | 1 | Access hit the interrupt controller page |

## Verification
The bench uses the default sizes of 128 KiB for both the BIOS and expansion ROMs. The alias therefore starts at 0xFFFE0000, both ROM masks are 0x1FFFF, and expansion indices start at 0x20000. With these values, every region edge in the first megabyte falls on an exact address the sweep visits. Installed RAM is switched between 1 MiB and 16 MiB. At 1 MiB the RAM top coincides with the end of the ROM area, so the below-RAM ROM path and the range-error path meet at one address. The sweep crosses every boundary under each SMRAM state, SMM mode, access kind, lookup enable and memory type.

// File: rtl/par_pkg.sv
package par_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned VIDEO_SZ = 32'h0002_0000;

  typedef enum logic [1:0] {
    TGT_RAM   = 2'd0,
    TGT_ROM   = 2'd1,
    TGT_VIDEO = 2'd2,
    TGT_NONE  = 2'd3
  } tgt_e;

  typedef struct packed {
    logic win;        // 0xA0000-0xBFFFF
    logic shadow;     // 0xC0000-0xFFFFF
    logic below_ram;
    logic alias_top;
    logic apic;
  } region_t;

  typedef struct packed {
    tgt_e              tgt;
    logic [ADDR_W-1:0] index;
    logic [7:0]        rdata;
    logic              range_err;
    logic              type_err;
    logic              apic_hit;
  } route_t;
endpackage

// File: rtl/par_smram_ctrl.sv
module par_smram_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic open_i,
  input  logic lock_i,
  input  logic clr_i,
  output logic avail_o,
  output logic open_o,
  output logic lock_o,
  output logic data_ok_o
);
  logic avail_q, open_q, lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      avail_q <= 1'b0;
      open_q  <= 1'b0;
      lock_q  <= 1'b0;
    end else if (clr_i) begin
      avail_q <= 1'b0;
      open_q  <= 1'b0;
      lock_q  <= 1'b0;
    end else if (set_i) begin
      avail_q <= 1'b1;
      open_q  <= open_i;
      lock_q  <= lock_i;
    end
  end

  assign avail_o   = avail_q;
  assign open_o    = open_q;
  assign lock_o    = lock_q;
  assign data_ok_o = avail_q && (open_q || !lock_q);
endmodule

// File: rtl/par_region_decode.sv
module par_region_decode
  import par_pkg::*;
#(
  parameter int unsigned BIOS_BYTES = 32'h0002_0000,
  parameter int unsigned EXP_BYTES  = 32'h0002_0000,
  parameter int unsigned MB_W       = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [MB_W-1:0]   ram_mb_i,
  input  logic [19:0]       apic_page_i,
  output region_t           region_o,
  output logic [ADDR_W-1:0] rom_index_o,
  output logic [3:0]        seg_o
);
  localparam logic [ADDR_W-1:0] BIOS_MASK  = ADDR_W'(BIOS_BYTES - 1);
  localparam logic [ADDR_W-1:0] EXP_MASK   = ADDR_W'(EXP_BYTES - 1);
  localparam logic [ADDR_W-1:0] ALIAS_BASE = ~BIOS_MASK;
  localparam int unsigned       TOP_W      = MB_W + 21;

  logic [TOP_W-1:0] ram_top;
  assign ram_top = TOP_W'(ram_mb_i) << 20;

  always_comb begin
    region_o.win       = (addr_i[31:17] == 15'h0005);
    region_o.shadow    = (addr_i[31:18] == 14'h0003);
    region_o.below_ram = (TOP_W'(addr_i) < ram_top);
    region_o.alias_top = (addr_i >= ALIAS_BASE);
    region_o.apic      = (addr_i[31:12] == apic_page_i);
  end

  // bit 17 separates the BIOS half from the expansion half of the ROM area
  assign rom_index_o = addr_i[17] ? (addr_i & BIOS_MASK)
                                  : ((addr_i & EXP_MASK) + ADDR_W'(BIOS_BYTES));
  assign seg_o = addr_i[17:14];
endmodule

// File: rtl/par_route_sel.sv
module par_route_sel
  import par_pkg::*;
#(
  parameter int unsigned BIOS_BYTES = 32'h0002_0000,
  parameter int unsigned MT_W       = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic              code_i,
  input  logic              smm_i,
  input  logic              avail_i,
  input  logic              open_i,
  input  logic              pci_en_i,
  input  logic [MT_W-1:0]   mem_type_i,
  input  region_t           region_i,
  input  logic [ADDR_W-1:0] rom_index_i,
  output route_t            route_o
);
  localparam logic [ADDR_W-1:0] BIOS_MASK  = ADDR_W'(BIOS_BYTES - 1);
  localparam logic [ADDR_W-1:0] VIDEO_MASK = ADDR_W'(VIDEO_SZ - 1);
  localparam logic [MT_W-1:0]   MT_ROM     = MT_W'(0);
  localparam logic [MT_W-1:0]   MT_RAM     = MT_W'(1);

  logic fetch, win_ram;
  assign fetch   = code_i && !write_i;
  assign win_ram = fetch ? (avail_i && (open_i || smm_i)) : open_i;

  always_comb begin
    route_o     = '0;
    route_o.tgt = TGT_NONE;
    if (region_i.apic) begin
      route_o.apic_hit = 1'b1;
    end else if (region_i.win) begin
      route_o.tgt   = win_ram ? TGT_RAM : TGT_VIDEO;
      route_o.index = win_ram ? addr_i : (addr_i & VIDEO_MASK);
    end else if (pci_en_i && region_i.shadow) begin
      if (mem_type_i == MT_RAM) begin
        route_o.tgt   = TGT_RAM;
        route_o.index = addr_i;
      end else if (mem_type_i == MT_ROM) begin
        if (!write_i) begin
          route_o.tgt   = TGT_ROM;
          route_o.index = rom_index_i;
        end
      end else begin
        route_o.type_err = 1'b1;
      end
    end else if (region_i.below_ram) begin
      if (!region_i.shadow) begin
        route_o.tgt   = TGT_RAM;
        route_o.index = addr_i;
      end else if (!write_i) begin
        route_o.tgt   = TGT_ROM;
        route_o.index = rom_index_i;
      end
    end else if (region_i.alias_top) begin
      if (!write_i) begin
        route_o.tgt   = TGT_ROM;
        route_o.index = addr_i & BIOS_MASK;
      end
    end else if (!write_i) begin
      route_o.rdata     = 8'hFF;
      route_o.range_err = 1'b1;
    end
  end
endmodule

// File: rtl/pc_addr_router.sv
module pc_addr_router
  import par_pkg::*;
#(
  parameter int unsigned BIOS_BYTES = 32'h0002_0000,
  parameter int unsigned EXP_BYTES  = 32'h0002_0000,
  parameter int unsigned MB_W       = 12,
  parameter int unsigned MT_W       = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [31:0]       req_addr_i,
  input  logic              req_write_i,
  input  logic              req_code_i,
  input  logic              smm_mode_i,
  input  logic              smram_set_i,
  input  logic              smram_open_i,
  input  logic              smram_lock_i,
  input  logic              smram_clr_i,
  input  logic              pci_en_i,
  input  logic [MT_W-1:0]   mem_type_i,
  input  logic [MB_W-1:0]   ram_mb_i,
  input  logic [19:0]       apic_page_i,
  output logic [3:0]        shadow_seg_o,
  output logic              smram_data_ok_o,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_target_o,
  output logic [31:0]       rsp_index_o,
  output logic [7:0]        rsp_rdata_o,
  output logic              rsp_range_err_o,
  output logic              rsp_type_err_o,
  output logic              rsp_apic_o
);
  logic              sm_avail, sm_open, sm_lock;
  region_t           region;
  logic [ADDR_W-1:0] rom_index;
  route_t            route_d, route_q;
  logic              valid_q;

  par_smram_ctrl u_smram (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (smram_set_i),
    .open_i    (smram_open_i),
    .lock_i    (smram_lock_i),
    .clr_i     (smram_clr_i),
    .avail_o   (sm_avail),
    .open_o    (sm_open),
    .lock_o    (sm_lock),
    .data_ok_o (smram_data_ok_o)
  );

  par_region_decode #(
    .BIOS_BYTES (BIOS_BYTES),
    .EXP_BYTES  (EXP_BYTES),
    .MB_W       (MB_W)
  ) u_decode (
    .addr_i      (req_addr_i),
    .ram_mb_i    (ram_mb_i),
    .apic_page_i (apic_page_i),
    .region_o    (region),
    .rom_index_o (rom_index),
    .seg_o       (shadow_seg_o)
  );

  par_route_sel #(
    .BIOS_BYTES (BIOS_BYTES),
    .MT_W       (MT_W)
  ) u_route (
    .addr_i      (req_addr_i),
    .write_i     (req_write_i),
    .code_i      (req_code_i),
    .smm_i       (smm_mode_i),
    .avail_i     (sm_avail),
    .open_i      (sm_open),
    .pci_en_i    (pci_en_i),
    .mem_type_i  (mem_type_i),
    .region_i    (region),
    .rom_index_i (rom_index),
    .route_o     (route_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q     <= 1'b0;
      route_q     <= '0;
      route_q.tgt <= TGT_NONE;
    end else begin
      valid_q <= req_valid_i;
      if (req_valid_i) route_q <= route_d;
    end
  end

  assign rsp_valid_o     = valid_q;
  assign rsp_target_o    = route_q.tgt;
  assign rsp_index_o     = route_q.index;
  assign rsp_rdata_o     = route_q.rdata;
  assign rsp_range_err_o = route_q.range_err;
  assign rsp_type_err_o  = route_q.type_err;
  assign rsp_apic_o      = route_q.apic_hit;

  // locked bit only shapes data_ok inside the control block
  logic unused_lock;
  assign unused_lock = sm_lock;
endmodule

// File: rtl/par_checker.sv
module par_checker #(
  parameter int unsigned BIOS_BYTES = 32'h0002_0000
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic [31:0] req_addr_i,
  input logic        req_write_i,
  input logic [19:0] apic_page_i,
  input logic        smram_clr_i,
  input logic        smram_data_ok_o,
  input logic        rsp_valid_o,
  input logic [1:0]  rsp_target_o,
  input logic [7:0]  rsp_rdata_o,
  input logic        rsp_range_err_o,
  input logic        rsp_type_err_o,
  input logic        rsp_apic_o
);
  localparam logic [31:0] ALIAS_BASE = ~(32'(BIOS_BYTES) - 32'd1);

  a_r1_rsp_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  a_r1_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  a_r4_clear_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smram_clr_i |=> !smram_data_ok_o);
  a_r7_type_err_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_type_err_o) |-> (rsp_target_o == 2'd3));
  a_r11_range_ff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_range_err_o) |-> (rsp_rdata_o == 8'hFF && rsp_target_o == 2'd3));
  a_r12_apic_veto: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_addr_i[31:12] == apic_page_i) |=> (rsp_apic_o && rsp_target_o == 2'd3));
  a_r9_alias_write_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && req_addr_i >= ALIAS_BASE && req_addr_i[31:12] != apic_page_i)
    |=> (rsp_target_o == 2'd3 && !rsp_range_err_o));
  a_r13_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> ($countones({rsp_range_err_o, rsp_type_err_o, rsp_apic_o}) <= 1));
endmodule

bind pc_addr_router par_checker #(.BIOS_BYTES(BIOS_BYTES)) u_par_checker (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_addr_i      (req_addr_i),
  .req_write_i     (req_write_i),
  .apic_page_i     (apic_page_i),
  .smram_clr_i     (smram_clr_i),
  .smram_data_ok_o (smram_data_ok_o),
  .rsp_valid_o     (rsp_valid_o),
  .rsp_target_o    (rsp_target_o),
  .rsp_rdata_o     (rsp_rdata_o),
  .rsp_range_err_o (rsp_range_err_o),
  .rsp_type_err_o  (rsp_type_err_o),
  .rsp_apic_o      (rsp_apic_o)
);

// File: tb/tb_pc_addr_router.sv
module tb_pc_addr_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0, req_code = 1'b0, smm = 1'b0;
  logic        sm_set = 1'b0, sm_open = 1'b0, sm_lock = 1'b0, sm_clr = 1'b0;
  logic        pci_en = 1'b0;
  logic [1:0]  mem_type = '0;
  logic [11:0] ram_mb = 12'd16;
  logic [19:0] apic_page = 20'hFEE00;
  logic [3:0]  seg;
  logic        data_ok, rsp_valid, rerr, terr, apic_hit;
  logic [1:0]  tgt;
  logic [31:0] idx;
  logic [7:0]  rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // bench-side copy of the SMRAM state, from R4
  bit b_av = 0, b_en = 0, b_rs = 0;

  typedef struct packed {
    logic [1:0]  tgt;
    logic [31:0] idx;
    logic [7:0]  rdata;
    logic        rerr, terr, apic;
    logic [31:0] addr;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  pc_addr_router dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_write_i(req_write), .req_code_i(req_code), .smm_mode_i(smm),
    .smram_set_i(sm_set), .smram_open_i(sm_open), .smram_lock_i(sm_lock),
    .smram_clr_i(sm_clr), .pci_en_i(pci_en), .mem_type_i(mem_type),
    .ram_mb_i(ram_mb), .apic_page_i(apic_page), .shadow_seg_o(seg),
    .smram_data_ok_o(data_ok), .rsp_valid_o(rsp_valid), .rsp_target_o(tgt),
    .rsp_index_o(idx), .rsp_rdata_o(rdata), .rsp_range_err_o(rerr),
    .rsp_type_err_o(terr), .rsp_apic_o(apic_hit)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rom_idx(input logic [31:0] a);
    return a[17] ? (a & 32'h1FFFF) : ((a & 32'h1FFFF) + 32'h20000);  // R8
  endfunction

  function automatic exp_t model(input logic [31:0] a, input bit wr, input bit cd);
    exp_t e;
    bit   use_ram;
    e = '0; e.tgt = 2'd3; e.addr = a;
    if (a[31:12] == apic_page) e.apic = 1;                          // R12
    else if (a >= 32'hA0000 && a <= 32'hBFFFF) begin
      use_ram = (cd && !wr) ? (b_av && (b_en || smm)) : b_en;       // R2 R3
      e.tgt = use_ram ? 2'd0 : 2'd2;
      e.idx = use_ram ? a : (a & 32'h1FFFF);
    end else if (pci_en && a >= 32'hC0000 && a <= 32'hFFFFF) begin
      if (mem_type == 2'd1) begin e.tgt = 2'd0; e.idx = a; end      // R5 R6
      else if (mem_type == 2'd0) begin
        if (!wr) begin e.tgt = 2'd1; e.idx = rom_idx(a); end
      end else e.terr = 1;                                          // R7
    end else if ({1'b0, a} < ({21'd0, ram_mb} << 20)) begin
      if (a >= 32'hC0000 && a <= 32'hFFFFF) begin                   // R10
        if (!wr) begin e.tgt = 2'd1; e.idx = rom_idx(a); end
      end else begin e.tgt = 2'd0; e.idx = a; end                   // R13
    end else if (a >= 32'hFFFE0000) begin                           // R9
      if (!wr) begin e.tgt = 2'd1; e.idx = a & 32'h1FFFF; end
    end else if (!wr) begin e.rdata = 8'hFF; e.rerr = 1; end        // R11
    return e;
  endfunction

  task automatic drive_req(input logic [31:0] a, input bit wr, input bit cd);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_code = cd;
    sb_q.push_back(model(a, wr, cd));
    #1 check(seg == a[17:14], "R5 shadow_seg", 64'(seg), 64'(a[17:14]));
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic smram_cmd(input bit set, input bit clr, input bit op, input bit lk);
    @(negedge clk);
    req_valid = 1'b0;
    sm_set = set; sm_clr = clr; sm_open = op; sm_lock = lk;
    @(negedge clk);
    sm_set = 0; sm_clr = 0;
    if (clr) begin b_av = 0; b_en = 0; b_rs = 0; end
    else if (set) begin b_av = 1; b_en = op; b_rs = lk; end
    check(data_ok == (b_av && (b_en || !b_rs)), "R4 smram_data_ok",
          64'(data_ok), 64'(b_av && (b_en || !b_rs)));
  endtask

  // scoreboard monitor, R1
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rsp_valid) begin
        if (sb_q.size() == 0) check(0, "R1 unexpected response", 64'(tgt), 64'd0);
        else begin
          exp_t e;
          e = sb_q.pop_front();
          check(tgt == e.tgt && idx == e.idx && rdata == e.rdata &&
                rerr == e.rerr && terr == e.terr && apic_hit == e.apic,
                $sformatf("R1-route addr=%h", e.addr),
                {20'd0, tgt, idx, rdata, rerr, terr, apic_hit},
                {20'd0, e.tgt, e.idx, e.rdata, e.rerr, e.terr, e.apic});
        end
      end
    end
  end

  localparam int N_ADDR = 14;
  function automatic logic [31:0] pick_addr(input int i, input logic [11:0] mb);
    case (i)
      0: return 32'h0009FFFF;  1: return 32'h000A0000;
      2: return 32'h000BFFFF;  3: return 32'h000C0000;
      4: return 32'h000DFFFF;  5: return 32'h000E0000;
      6: return 32'h000FFFFF;  7: return ({20'd0, mb} << 20) - 32'd1;
      8: return {20'd0, mb} << 20;  9: return 32'hFFFE0000;
      10: return 32'hFFFFFFFF; 11: return 32'h00001234;
      12: return 32'hFEE00010; default: return 32'h000C8765;
    endcase
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R1 reset rsp_valid", 64'(rsp_valid), 64'd0);
    check(data_ok == 1'b0, "R4 reset data_ok", 64'(data_ok), 64'd0);

    // R4: set/clear and clear-over-set priority
    smram_cmd(1, 0, 0, 0);
    smram_cmd(1, 0, 0, 1);
    smram_cmd(1, 0, 1, 1);
    smram_cmd(1, 1, 1, 0);
    check(data_ok == 1'b0, "R4 clear wins", 64'(data_ok), 64'd0);

    for (int m = 0; m < 2; m++) begin
      ram_mb = (m == 0) ? 12'd16 : 12'd1;
      for (int s = 0; s < 4; s++) begin
        case (s)
          0: smram_cmd(0, 1, 0, 0);
          1: smram_cmd(1, 0, 0, 0);
          2: smram_cmd(1, 0, 0, 1);
          default: smram_cmd(1, 0, 1, 0);
        endcase
        for (int k = 0; k < 16; k++) begin
          @(negedge clk);
          smm = k[0]; pci_en = k[1]; mem_type = k[3:2];
          for (int i = 0; i < N_ADDR; i++)
            for (int w = 0; w < 2; w++)
              for (int c = 0; c < 2; c++)
                drive_req(pick_addr(i, ram_mb), w[0], c[0]);
          idle();
        end
      end
    end
    idle();
    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R1 all responses seen", 64'(sb_q.size()), 64'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule